// File: doc/BRIEF.md
# Two-Phase Encoder Counter with Cascade

This block counts position from two-phase external inputs such as a rotary or linear encoder. It holds two 16-bit counting channels. The first channel always reads phase pins A and B. The second channel reads either the same A/B pair or a separate C/D pair. Each channel has its own counting mode, count value, compare value, clear control and direction flag. A shared configuration register can join the two channels into a single 32-bit counter. In that case the first channel is the low half and the second is the high half.

Software uses a simple synchronous write port and a combinational read port. The phase pins are asynchronous. They pass through a two-flop synchronizer, and edge detection then compares the synchronized level with its value one cycle earlier. A step in any mode reaches the count at the third rising clock edge after a pin changes.

Top module: `enc_cnt_timer`

## Requirements
- R1: Mode field bits [3:0] of the mode register (address 0 for the first channel, 1 for the second) set the counting mode. Code 4 is x4 quadrature: every edge of A or B steps the count. It counts up when A leads B, meaning an A change leaves A different from B, or a B change leaves B equal to A. Otherwise it counts down.
- R2: In code 4, if A and B both change in the same sample, the count does not change.
- R3: Code 5 is pulse/direction. Only a rising edge of A steps the count. It counts up if B is 1 and down if B is 0. A falling edge of A does not count.
- R4: Code 7 is x2 on B. Every change of B steps the count, up when the new B equals A and down otherwise. Changes of A alone do not count.
- R5: Any other mode code, including the reset value 0, freezes the count.
- R6: Status bit 7 (address 8 for the first channel, 9 for the second) holds the direction of the last step: 1 for up, 0 for down.
- R7: When control bit 0 (address 2 or 3) is set, a step taken while the count equals the compare value (address 6 or 7) loads 0.
- R8: With compare clear off, the count wraps modulo 2^16 in both directions.
- R9: Configuration bit 0 (address 10) cascades the channels. The high half steps only when the low half wraps, and it clears together with the low half. The 32-bit count is at address 11 and the 32-bit compare at address 12. The first channel's control bit enables the clear against the 32-bit compare.
- R10: Configuration bit 1 selects the second channel's inputs: 0 selects A/B and 1 selects C/D.
- R11: After reset, counts, status and modes are 0, and both compare values are all ones. The 32-bit compare reads as 0xFFFFFFFF.
- R12: Software can write a count at addresses 4, 5 or 11. The written value is read back, and a write wins over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ph_a_i | input | 1 | Phase input A |
| ph_b_i | input | 1 | Phase input B |
| ph_c_i | input | 1 | Phase input C |
| ph_d_i | input | 1 | Phase input D |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |

## Verification
A pin change is captured by two synchronizer flops, and the edge is detected against a third register. The count and direction flag therefore change at the third rising edge after the change. The bench drives pins on a falling edge and reads back after exactly three more falling edges. A register write lands on the rising edge inside its strobe, and reads are taken combinationally shortly after the address settles on a falling edge. Every expected count is computed from the mode rules and the pin sequence applied.

// File: rtl/enc_cnt_pkg.sv
package enc_cnt_pkg;
  localparam int MODE_W = 4;
  localparam int ADDR_W = 4;

  localparam logic [MODE_W-1:0] MD_QUAD4  = 4'd4;
  localparam logic [MODE_W-1:0] MD_PDIR   = 4'd5;
  localparam logic [MODE_W-1:0] MD_QUAD2B = 4'd7;

  localparam logic [ADDR_W-1:0] A_MODE1 = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE2 = 4'd1;
  localparam logic [ADDR_W-1:0] A_CTL1  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CTL2  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CNT1  = 4'd4;
  localparam logic [ADDR_W-1:0] A_CNT2  = 4'd5;
  localparam logic [ADDR_W-1:0] A_CMP1  = 4'd6;
  localparam logic [ADDR_W-1:0] A_CMP2  = 4'd7;
  localparam logic [ADDR_W-1:0] A_STAT1 = 4'd8;
  localparam logic [ADDR_W-1:0] A_STAT2 = 4'd9;
  localparam logic [ADDR_W-1:0] A_CFG   = 4'd10;
  localparam logic [ADDR_W-1:0] A_CNT32 = 4'd11;
  localparam logic [ADDR_W-1:0] A_CMP32 = 4'd12;
endpackage

// File: rtl/phase_front.sv
module phase_front #(
  parameter int NPIN = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] cur_o,
  output logic [NPIN-1:0] prv_o
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic s1_q, s2_q, p_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        p_q  <= 1'b0;
      end else begin
        s1_q <= pin_i[i];
        s2_q <= s1_q;
        p_q  <= s2_q;
      end
    end
    assign cur_o[i] = s2_q;
    assign prv_o[i] = p_q;
  end
endmodule

// File: rtl/phase_decode.sv
module phase_decode
  import enc_cnt_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              a_i,
  input  logic              a_q_i,
  input  logic              b_i,
  input  logic              b_q_i,
  output logic              step_o,
  output logic              up_o
);
  logic a_chg, b_chg;
  assign a_chg = a_i ^ a_q_i;
  assign b_chg = b_i ^ b_q_i;

  always_comb begin
    step_o = 1'b0;
    up_o   = 1'b0;
    case (mode_i)
      MD_QUAD4: begin
        step_o = a_chg ^ b_chg;  // simultaneous change is invalid
        up_o   = a_chg ? (a_i != b_i) : (b_i == a_i);
      end
      MD_PDIR: begin
        step_o = a_i & ~a_q_i;
        up_o   = b_i;
      end
      MD_QUAD2B: begin
        step_o = b_chg;
        up_o   = (b_i == a_i);
      end
      default: ;
    endcase
  end

  always_comb begin
    // R2
    if (mode_i == MD_QUAD4 && a_chg && b_chg) inv_pair_chk: assert (!step_o);
    // R4
    if (mode_i == MD_QUAD2B && !b_chg) a_ignored_chk: assert (!step_o);
    // R3
    if (mode_i == MD_PDIR && step_o) pdir_rise_chk: assert (a_i && !a_q_i);
  end
endmodule

// File: rtl/cnt_half.sv
module cnt_half #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         step_i,
  input  logic         up_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         dir_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         dir_q;

  assign wrap_o = step_i & ~clr_i & ~wr_i &
                  (up_i ? (cnt_q == '1) : (cnt_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (wr_i) begin
      cnt_q <= wdata_i;
    end else if (step_i) begin
      dir_q <= up_i;
      if (clr_i)     cnt_q <= '0;
      else if (up_i) cnt_q <= cnt_q + 1'b1;
      else           cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign dir_o = dir_q;

  // R12
  wr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wdata_i));
  // R7
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && clr_i && !wr_i |=> cnt_q == '0);
  // R8
  up_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && up_i && !clr_i && !wr_i && cnt_q == '1 |=> cnt_q == '0);
  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !wr_i |=> $stable(cnt_q));
  // R6
  dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !wr_i |=> dir_q == $past(up_i));
endmodule

// File: rtl/enc_cnt_timer.sv
module enc_cnt_timer
  import enc_cnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ph_a_i,
  input  logic                 ph_b_i,
  input  logic                 ph_c_i,
  input  logic                 ph_d_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [2*CNT_W-1:0]   wdata_i,
  output logic [2*CNT_W-1:0]   rdata_o
);
  localparam int DATA_W = 2 * CNT_W;
  localparam int NPIN   = 4;
  localparam int DIR_B  = 7;

  logic [MODE_W-1:0] mode1_q, mode2_q;
  logic              ctl1_q, ctl2_q, casc_q, sel_q;
  logic [CNT_W-1:0]  cmp1_q, cmp2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode1_q <= '0;
      mode2_q <= '0;
      ctl1_q  <= 1'b0;
      ctl2_q  <= 1'b0;
      casc_q  <= 1'b0;
      sel_q   <= 1'b0;
      cmp1_q  <= '1;
      cmp2_q  <= '1;
    end else if (wr_en_i) begin
      case (addr_i)
        A_MODE1: mode1_q <= wdata_i[MODE_W-1:0];
        A_MODE2: mode2_q <= wdata_i[MODE_W-1:0];
        A_CTL1:  ctl1_q  <= wdata_i[0];
        A_CTL2:  ctl2_q  <= wdata_i[0];
        A_CMP1:  cmp1_q  <= wdata_i[CNT_W-1:0];
        A_CMP2:  cmp2_q  <= wdata_i[CNT_W-1:0];
        A_CFG:   {sel_q, casc_q} <= wdata_i[1:0];
        A_CMP32: {cmp2_q, cmp1_q} <= wdata_i;
        default: ;
      endcase
    end
  end

  logic [NPIN-1:0] cur, prv;
  phase_front #(.NPIN(NPIN)) u_front (
    .clk_i, .rst_ni,
    .pin_i ({ph_d_i, ph_c_i, ph_b_i, ph_a_i}),
    .cur_o (cur),
    .prv_o (prv)
  );

  logic step1, up1, dstep2, dup2;
  phase_decode u_dec1 (
    .mode_i (mode1_q), .a_i (cur[0]), .a_q_i (prv[0]),
    .b_i (cur[1]), .b_q_i (prv[1]), .step_o (step1), .up_o (up1)
  );
  phase_decode u_dec2 (
    .mode_i (mode2_q),
    .a_i (sel_q ? cur[2] : cur[0]), .a_q_i (sel_q ? prv[2] : prv[0]),
    .b_i (sel_q ? cur[3] : cur[1]), .b_q_i (sel_q ? prv[3] : prv[1]),
    .step_o (dstep2), .up_o (dup2)
  );

  logic [CNT_W-1:0] cnt1, cnt2, wd2;
  logic             dir1, dir2, wrap1, wrap2_unused;
  logic             wr1, wr2, clr1, clr2, step2, up2;

  assign wr1 = wr_en_i & (addr_i == A_CNT1 || addr_i == A_CNT32);
  assign wr2 = wr_en_i & (addr_i == A_CNT2 || addr_i == A_CNT32);
  assign wd2 = (addr_i == A_CNT32) ? wdata_i[DATA_W-1:CNT_W] : wdata_i[CNT_W-1:0];

  assign clr1  = ctl1_q & (casc_q ? ({cnt2, cnt1} == {cmp2_q, cmp1_q}) : (cnt1 == cmp1_q));
  assign clr2  = casc_q ? clr1 : (ctl2_q & (cnt2 == cmp2_q));
  assign step2 = casc_q ? ((step1 & clr1 & ~wr1) | wrap1) : dstep2;
  assign up2   = casc_q ? up1 : dup2;

  cnt_half #(.W(CNT_W)) u_lo (
    .clk_i, .rst_ni, .wr_i (wr1), .wdata_i (wdata_i[CNT_W-1:0]),
    .step_i (step1), .up_i (up1), .clr_i (clr1),
    .cnt_o (cnt1), .dir_o (dir1), .wrap_o (wrap1)
  );
  cnt_half #(.W(CNT_W)) u_hi (
    .clk_i, .rst_ni, .wr_i (wr2), .wdata_i (wd2),
    .step_i (step2), .up_i (up2), .clr_i (clr2),
    .cnt_o (cnt2), .dir_o (dir2), .wrap_o (wrap2_unused)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_MODE1: rdata_o = DATA_W'(mode1_q);
      A_MODE2: rdata_o = DATA_W'(mode2_q);
      A_CTL1:  rdata_o = DATA_W'(ctl1_q);
      A_CTL2:  rdata_o = DATA_W'(ctl2_q);
      A_CNT1:  rdata_o = DATA_W'(cnt1);
      A_CNT2:  rdata_o = DATA_W'(cnt2);
      A_CMP1:  rdata_o = DATA_W'(cmp1_q);
      A_CMP2:  rdata_o = DATA_W'(cmp2_q);
      A_STAT1: rdata_o[DIR_B] = dir1;
      A_STAT2: rdata_o[DIR_B] = dir2;
      A_CFG:   rdata_o = DATA_W'({sel_q, casc_q});
      A_CNT32: rdata_o = {cnt2, cnt1};
      A_CMP32: rdata_o = {cmp2_q, cmp1_q};
      default: ;
    endcase
  end

  // R9
  casc_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_q && !wr2 && !step1 |=> $stable(cnt2));
endmodule

// File: tb/enc_cnt_timer_bench.sv
module enc_cnt_timer_bench;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pa = 0, pb = 0, pc = 0, pd = 0;
  logic        wr_en = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  enc_cnt_timer u_enc_cnt_timer (
    .clk_i (clk), .rst_ni (rst_n),
    .ph_a_i (pa), .ph_b_i (pb), .ph_c_i (pc), .ph_d_i (pd),
    .wr_en_i (wr_en), .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata)
  );

  // x4 quadrature walk from AB=00: four up, four down, one more down (wrap)
  localparam logic [1:0]  QSEQ [9] = '{2'b10, 2'b11, 2'b01, 2'b00, 2'b01, 2'b11, 2'b10, 2'b00, 2'b01};
  localparam logic [15:0] QEXP [9] = '{16'd1, 16'd2, 16'd3, 16'd4, 16'd3, 16'd2, 16'd1, 16'd0, 16'hFFFF};
  localparam logic        QDIR [9] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pins(input logic na, input logic nb, input logic nc, input logic nd);
    @(negedge clk);
    pa = na; pb = nb; pc = nc; pd = nd;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, rdata, exp);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(4'd4, 32'h0, "R11");
    chk(4'd6, 32'h0000FFFF, "R11");
    chk(4'd12, 32'hFFFFFFFF, "R11");
    chk(4'd8, 32'h0, "R11");
    chk(4'd0, 32'h0, "R11");
    // R5 mode 0 freezes
    pins(1, 0, 0, 0);
    pins(0, 0, 0, 0);
    chk(4'd4, 32'h0, "R5");
    // R1 R6 R8 quadrature table
    wr(4'd0, 32'd4);
    for (int i = 0; i < 9; i++) begin
      pins(QSEQ[i][1], QSEQ[i][0], 0, 0);
      chk(4'd4, {16'h0, QEXP[i]}, "R1/R8");
      chk(4'd8, {24'h0, QDIR[i], 7'h0}, "R6");
    end
    // R2 both phases change together: no step
    pins(1, 0, 0, 0);
    chk(4'd4, 32'h0000FFFF, "R2");
    // R12 direct write
    wr(4'd4, 32'h1234);
    chk(4'd4, 32'h1234, "R12");
    pins(0, 0, 0, 0);
    chk(4'd4, 32'h1233, "R1");
    // R3 pulse/direction
    wr(4'd0, 32'd5);
    wr(4'd4, 32'd10);
    pins(0, 1, 0, 0);
    chk(4'd4, 32'd10, "R3");
    pins(1, 1, 0, 0);
    chk(4'd4, 32'd11, "R3");
    pins(0, 1, 0, 0);
    chk(4'd4, 32'd11, "R3");
    pins(0, 0, 0, 0);
    pins(1, 0, 0, 0);
    chk(4'd4, 32'd10, "R3");
    // R4 x2 on B
    wr(4'd0, 32'd7);
    wr(4'd4, 32'h20);
    pins(0, 0, 0, 0);
    chk(4'd4, 32'h20, "R4");
    pins(0, 1, 0, 0);
    chk(4'd4, 32'h1F, "R4");
    pins(1, 1, 0, 0);
    chk(4'd4, 32'h1F, "R4");
    pins(1, 0, 0, 0);
    chk(4'd4, 32'h1E, "R4");
    pins(1, 1, 0, 0);
    chk(4'd4, 32'h1F, "R4");
    // R7 compare clear
    wr(4'd0, 32'd4);
    wr(4'd4, 32'd0);
    wr(4'd6, 32'd2);
    wr(4'd2, 32'd1);
    pins(0, 1, 0, 0);
    chk(4'd4, 32'd1, "R7");
    pins(0, 0, 0, 0);
    chk(4'd4, 32'd2, "R7");
    pins(1, 0, 0, 0);
    chk(4'd4, 32'd0, "R7");
    wr(4'd2, 32'd0);
    wr(4'd6, 32'hFFFF);
    // R9 cascade carry, borrow and 32-bit compare
    wr(4'd10, 32'd1);
    wr(4'd11, 32'h0000FFFF);
    chk(4'd11, 32'h0000FFFF, "R12");
    pins(1, 1, 0, 0);
    chk(4'd11, 32'h00010000, "R9");
    pins(1, 0, 0, 0);
    chk(4'd11, 32'h0000FFFF, "R9");
    wr(4'd12, 32'h00010000);
    wr(4'd2, 32'd1);
    pins(1, 1, 0, 0);
    chk(4'd11, 32'h00010000, "R9");
    pins(0, 1, 0, 0);
    chk(4'd11, 32'h0, "R9");
    wr(4'd2, 32'd0);
    // R10 input pair select for second channel
    wr(4'd10, 32'd2);
    wr(4'd1, 32'd4);
    wr(4'd5, 32'd0);
    pins(1, 1, 0, 0);
    chk(4'd5, 32'd0, "R10");
    pins(1, 1, 1, 0);
    chk(4'd5, 32'd1, "R10");
    wr(4'd10, 32'd0);
    pins(1, 1, 0, 0);
    chk(4'd5, 32'd1, "R10");
    pins(0, 1, 0, 0);
    chk(4'd5, 32'd2, "R10");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule